// File: doc/BRIEF.md
# Multi-Master Cache Maintenance Queue

This block is the front end through which several processors issue maintenance work (invalidate, clean, flush) to a shared cache. Each processor has its own simple register port. All ports reach one shared set of command registers: a mode word, a start address and a byte size. A processor gains the right to write these registers by writing the mode word first. It gives the right back by reading its own registration-status register. That read is also the moment the command is registered: it goes into a small in-order queue, unless the queue is full.

A stub engine pops the queue one command at a time. It spends a fixed number of cycles on each cache line the command covers, and a whole-cache command covers a fixed number of lines. When a command that asked for notification finishes, a completion flag is raised in the status register of the processor that issued it. That processor clears the flag itself. A sync primitive lets any processor stall a read until every queued and running command has drained.

Each port is a request/acknowledge stream. A transfer happens in a cycle where `bus_sel` and `bus_ready` are both high. Writes are never back-pressured. A read of the primitive register after a sync request is held off, with `bus_ready` low, until the queue is empty and the engine is idle. The requester must hold its request stable while it waits.

Top module: `maint_queue`

## Requirements
- R1: After reset every processor reads 0 from its registration-status register (index 3) and its operation-status register (index 4). All `bus_ready` bits are high and `exec_busy` is low.
- R2: The first processor to write the mode register (index 0) becomes owner. If several write it in the same cycle, the lowest-numbered one wins. A mode write by any processor that does not become or remain owner sets that processor's fail bit (bit 0 of its registration status). Reading that register clears the fail bit.
- R3: Writes to the address (index 1) or size (index 2) register by a processor that is not the owner are discarded.
- R4: When the owner reads its registration status and the queue has room, the read returns 0, the command is queued, and ownership is released.
- R5: When the owner reads its registration status while the queue holds DEPTH commands, the read returns 3 (bit 1 full, bit 0 failed), the command is dropped, and ownership is released.
- R6: A range command (mode bits 18:17 = 0) covers ceil((address mod LINE_BYTES + size) / LINE_BYTES) lines. `exec_busy` stays high for max(1, lines × CYC_PER_LINE) cycles.
- R7: A whole-cache command (mode bits 18:17 = 1) keeps `exec_busy` high for ALL_LINES × CYC_PER_LINE cycles, whatever the address and size registers hold.
- R8: Bit 2 of the operation status is set when a command issued with mode bit 15 set finishes. It stays clear for a command issued without that bit. Writing a 1 to bit 2 of the operation status clears it.
- R9: Commands execute one at a time, in order of acceptance. Operation-status bit 1 shows that the engine is running a command of this processor. Bit 0 shows that one of its commands is waiting in the queue.
- R10: Writing 8 to the primitive register (index 5) arms a sync. The next read of that register is held with `bus_ready` low until the queue is empty and the engine is idle. Writing 9 does not arm a stall.
- R11: While busy, `exec_op` shows the command's operation code from mode bits 1:0 (0 invalidate, 1 clean, 2 flush), and `exec_whole` shows its scope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | NCPU | Per-processor access request |
| bus_we | input | NCPU | Per-processor write (1) or read (0) |
| bus_reg | input | NCPU*3 | Per-processor register index |
| bus_wdata | input | NCPU*DW | Per-processor write data |
| bus_rdata | output | NCPU*DW | Per-processor read data, valid while selected |
| bus_ready | output | NCPU | Per-processor acknowledge |
| exec_busy | output | 1 | Engine is executing a command |
| exec_op | output | 2 | Operation code of the running command |
| exec_whole | output | 1 | Running command covers the whole cache |

## Verification
The main function is tried with several command shapes:
- An aligned multi-line range with a stray tail byte, and an unaligned start. These separate correct line rounding from plain size division.
- A zero-size range, which shows the one-cycle floor.
- A whole-cache command carrying junk address and size, which shows that scope really bypasses those registers.

Contention is tried with simultaneous mode writes and with late writes from an outsider. These show that the lowest index wins and that non-owner writes do not leak into the command. A burst of five commands from three processors behind a long one fills the queue. It exposes the full report, the per-processor queued and running bits, and the execution order seen on `exec_op`. A sync read issued behind that burst separates a real drain stall from the non-stalling prefetch-flush code.

// File: rtl/maint_pkg.sv
package maint_pkg;
  localparam logic [2:0] RG_MODE  = 3'd0;
  localparam logic [2:0] RG_ADDR  = 3'd1;
  localparam logic [2:0] RG_SIZE  = 3'd2;
  localparam logic [2:0] RG_REGST = 3'd3;
  localparam logic [2:0] RG_OPST  = 3'd4;
  localparam logic [2:0] RG_PRIM  = 3'd5;

  localparam int MODE_NOTIFY_BIT = 15;
  localparam int MODE_SCOPE_LO   = 17;
  localparam int PRIM_SYNC       = 8;
  localparam int PRIM_PFFLUSH    = 9;

  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef struct packed {
    op_e  op;
    logic whole;
    logic notify;
  } ctl_t;
endpackage

// File: rtl/maint_owner.sv
module maint_owner #(
  parameter int NCPU = 3,
  localparam int IDW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] mode_wr,
  input  logic [NCPU-1:0] stat_rd,
  output logic            owner_vld,
  output logic [IDW-1:0]  owner_id,
  output logic            take_mode,
  output logic [IDW-1:0]  take_id,
  output logic [NCPU-1:0] fail_q
);
  logic [IDW-1:0]  first_id;
  logic            any_wr;
  logic [NCPU-1:0] ok_wr;

  always_comb begin
    first_id = '0;
    any_wr   = |mode_wr;
    for (int i = NCPU - 1; i >= 0; i--)
      if (mode_wr[i]) first_id = IDW'(i);
    for (int i = 0; i < NCPU; i++)
      ok_wr[i] = mode_wr[i] &&
                 (owner_vld ? (owner_id == IDW'(i)) : (first_id == IDW'(i)));
    take_mode = |ok_wr;
    take_id   = owner_vld ? owner_id : first_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_vld <= 1'b0;
      owner_id  <= '0;
      fail_q    <= '0;
    end else begin
      if (!owner_vld && any_wr) begin
        owner_vld <= 1'b1;
        owner_id  <= first_id;
      end else if (owner_vld && stat_rd[owner_id]) begin
        owner_vld <= 1'b0;
      end
      for (int i = 0; i < NCPU; i++) begin
        if (mode_wr[i] && !ok_wr[i]) fail_q[i] <= 1'b1;
        else if (stat_rd[i])         fail_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/maint_fifo.sv
module maint_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= din;
        wp      <= nxt(wp);
      end
      if (pop) rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/maint_engine.sv
module maint_engine
  import maint_pkg::*;
#(
  parameter int DW           = 32,
  parameter int LINE_BYTES   = 64,
  parameter int CYC_PER_LINE = 2,
  parameter int ALL_LINES    = 8,
  parameter int IDW          = 2,
  localparam int LB          = $clog2(LINE_BYTES),
  localparam int CW          = DW + $clog2(CYC_PER_LINE + 1) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  ctl_t          start_ctl,
  input  logic [DW-1:0] start_addr,
  input  logic [DW-1:0] start_size,
  input  logic [IDW-1:0] start_id,
  output logic          busy,
  output logic          fin,
  output ctl_t          cur_ctl,
  output logic [IDW-1:0] cur_id
);
  logic [CW-1:0] span, lines, dur, cnt;

  always_comb begin
    span  = CW'(start_addr[LB-1:0]) + CW'(start_size) + CW'(LINE_BYTES - 1);
    lines = span >> LB;
    dur   = start_ctl.whole ? CW'(ALL_LINES * CYC_PER_LINE)
                            : lines * CW'(CYC_PER_LINE);
    if (dur == '0) dur = CW'(1);
  end

  assign fin = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cur_ctl <= '0;
      cur_id  <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= dur;
      cur_ctl <= start_ctl;
      cur_id  <= start_id;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/maint_queue.sv
module maint_queue
  import maint_pkg::*;
#(
  parameter int NCPU         = 3,
  parameter int DEPTH        = 4,
  parameter int DW           = 32,
  parameter int LINE_BYTES   = 64,
  parameter int CYC_PER_LINE = 2,
  parameter int ALL_LINES    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCPU-1:0]    bus_sel,
  input  logic [NCPU-1:0]    bus_we,
  input  logic [NCPU*3-1:0]  bus_reg,
  input  logic [NCPU*DW-1:0] bus_wdata,
  output logic [NCPU*DW-1:0] bus_rdata,
  output logic [NCPU-1:0]    bus_ready,
  output logic               exec_busy,
  output logic [1:0]         exec_op,
  output logic               exec_whole
);
  localparam int IDW = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int CTW = $bits(ctl_t);
  localparam int EW  = IDW + CTW + 2 * DW;
  localparam int PCW = $clog2(DEPTH + 1);

  logic [NCPU-1:0] mode_wr, addr_wr, size_wr, regst_rd, opst_wr, prim_wr, prim_rd;
  logic [NCPU-1:0] done_q, sync_pend, queued, running;
  logic            owner_vld, take_mode;
  logic [IDW-1:0]  owner_id, take_id;
  logic [NCPU-1:0] fail_q;
  ctl_t            mode_q, eng_ctl, head_ctl;
  logic [DW-1:0]   addr_q, size_q, head_addr, head_size, take_data;
  logic [IDW-1:0]  eng_id, head_id;
  logic            q_push, q_pop, q_full, q_empty, eng_fin;
  logic [EW-1:0]   q_din, q_dout;
  logic [PCW-1:0]  pend_cnt [NCPU];

  // per-port decode
  for (genvar g = 0; g < NCPU; g++) begin : g_port
    logic [2:0]    rg;
    logic [DW-1:0] wd;
    logic          rd_acc;
    assign rg = bus_reg[g*3 +: 3];
    assign wd = bus_wdata[g*DW +: DW];
    assign rd_acc = bus_sel[g] && !bus_we[g];
    assign mode_wr[g]  = bus_sel[g] && bus_we[g] && rg == RG_MODE;
    assign addr_wr[g]  = bus_sel[g] && bus_we[g] && rg == RG_ADDR;
    assign size_wr[g]  = bus_sel[g] && bus_we[g] && rg == RG_SIZE;
    assign opst_wr[g]  = bus_sel[g] && bus_we[g] && rg == RG_OPST;
    assign prim_wr[g]  = bus_sel[g] && bus_we[g] && rg == RG_PRIM;
    assign regst_rd[g] = rd_acc && rg == RG_REGST;
    assign bus_ready[g] = !(rd_acc && rg == RG_PRIM && sync_pend[g] &&
                            (exec_busy || !q_empty));
    assign prim_rd[g]  = rd_acc && rg == RG_PRIM && bus_ready[g];
    assign queued[g]   = (pend_cnt[g] != '0);
    assign running[g]  = exec_busy && (eng_id == IDW'(g));

    always_comb begin
      bus_rdata[g*DW +: DW] = '0;
      if (rg == RG_REGST) begin
        if (owner_vld && owner_id == IDW'(g))
          bus_rdata[g*DW +: 2] = q_full ? 2'b11 : {1'b0, fail_q[g]};
        else
          bus_rdata[g*DW +: 2] = {1'b0, fail_q[g]};
      end else if (rg == RG_OPST) begin
        bus_rdata[g*DW +: 3] = {done_q[g], running[g], queued[g]};
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_q[g]    <= 1'b0;
        sync_pend[g] <= 1'b0;
        pend_cnt[g]  <= '0;
      end else begin
        if (eng_fin && eng_ctl.notify && eng_id == IDW'(g)) done_q[g] <= 1'b1;
        else if (opst_wr[g] && wd[2])                       done_q[g] <= 1'b0;
        if (prim_wr[g] && wd == DW'(PRIM_SYNC)) sync_pend[g] <= 1'b1;
        else if (prim_rd[g])                    sync_pend[g] <= 1'b0;
        pend_cnt[g] <= pend_cnt[g]
                     + PCW'(q_push && owner_id == IDW'(g))
                     - PCW'(q_pop && head_id == IDW'(g));
      end
    end
  end

  maint_owner #(.NCPU(NCPU)) u_owner (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .stat_rd(regst_rd),
    .owner_vld(owner_vld), .owner_id(owner_id),
    .take_mode(take_mode), .take_id(take_id), .fail_q(fail_q)
  );

  assign take_data = bus_wdata[take_id*DW +: DW];

  // shared command registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else begin
      if (take_mode) begin
        mode_q.op     <= op_e'(take_data[1:0]);
        mode_q.whole  <= (take_data[MODE_SCOPE_LO+1:MODE_SCOPE_LO] == 2'd1);
        mode_q.notify <= take_data[MODE_NOTIFY_BIT];
      end
      for (int i = 0; i < NCPU; i++) begin
        if (owner_vld && owner_id == IDW'(i)) begin
          if (addr_wr[i]) addr_q <= bus_wdata[i*DW +: DW];
          if (size_wr[i]) size_q <= bus_wdata[i*DW +: DW];
        end
      end
    end
  end

  assign q_push = owner_vld && regst_rd[owner_id] && !q_full;
  assign q_din  = {owner_id, mode_q, addr_q, size_q};
  assign {head_id, head_ctl, head_addr, head_size} = q_dout;
  assign q_pop  = !exec_busy && !q_empty;

  maint_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(q_pop),
    .dout(q_dout), .empty(q_empty), .full(q_full)
  );

  maint_engine #(
    .DW(DW), .LINE_BYTES(LINE_BYTES), .CYC_PER_LINE(CYC_PER_LINE),
    .ALL_LINES(ALL_LINES), .IDW(IDW)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .start(q_pop), .start_ctl(head_ctl),
    .start_addr(head_addr), .start_size(head_size), .start_id(head_id),
    .busy(exec_busy), .fin(eng_fin), .cur_ctl(eng_ctl), .cur_id(eng_id)
  );

  assign exec_op    = eng_ctl.op;
  assign exec_whole = eng_ctl.whole;
endmodule

// File: rtl/maint_queue_chk.sv
module maint_queue_chk #(
  parameter int NCPU = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push,
  input logic            pop,
  input logic            full,
  input logic            empty,
  input logic            busy,
  input logic            fin,
  input logic [NCPU-1:0] done,
  input logic [NCPU-1:0] ready,
  input logic [NCPU-1:0] queued,
  input logic            owner_vld,
  input logic [NCPU-1:0] mode_wr
);
  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r9_pop_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !busy);
  a_r8_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(done)) != '0) |-> $past(fin));
  a_r10_stall_only_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ready != '1) |-> (busy || !empty));
  a_r9_queued_means_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (queued != '0) |-> !empty);
  a_r2_owner_from_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owner_vld) |-> $past(mode_wr != '0));
endmodule

bind maint_queue maint_queue_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(q_push), .pop(q_pop), .full(q_full),
  .empty(q_empty), .busy(exec_busy), .fin(eng_fin), .done(done_q),
  .ready(bus_ready), .queued(queued), .owner_vld(owner_vld), .mode_wr(mode_wr)
);

// File: tb/maint_queue_tb.sv
module maint_queue_tb;
  localparam int NCPU = 3, DW = 32, LINE = 64, CPL = 2, ALLL = 8;
  localparam int MREG = 0, AREG = 1, SREG = 2, RSREG = 3, OSREG = 4, PREG = 5;

  logic clk = 0, rst_n = 0;
  logic [NCPU-1:0]    sel = '0, we = '0;
  logic [NCPU*3-1:0]  rg = '0;
  logic [NCPU*DW-1:0] wd = '0;
  logic [NCPU*DW-1:0] rdata;
  logic [NCPU-1:0]    rdy;
  logic exec_busy, exec_whole;
  logic [1:0] exec_op;
  int n_chk = 0, n_fail = 0;
  int last_stall;
  logic [1:0] oplog [16];
  int n_log = 0;
  logic prev_b = 0;

  always #10 clk = ~clk;

  maint_queue #(.NCPU(NCPU), .DEPTH(4), .DW(DW), .LINE_BYTES(LINE),
                .CYC_PER_LINE(CPL), .ALL_LINES(ALLL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_reg(rg),
    .bus_wdata(wd), .bus_rdata(rdata), .bus_ready(rdy),
    .exec_busy(exec_busy), .exec_op(exec_op), .exec_whole(exec_whole));

  initial forever begin
    @(negedge clk);
    if (exec_busy && !prev_b && n_log < 16) begin
      oplog[n_log] = exec_op;
      n_log++;
    end
    prev_b = exec_busy;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int c, int r, logic [31:0] d);
    @(negedge clk);
    sel[c] = 1; we[c] = 1; rg[c*3 +: 3] = 3'(r); wd[c*DW +: DW] = d;
    @(posedge clk); #1;
    sel[c] = 0; we[c] = 0;
  endtask

  task automatic wr2(int c0, int c1, int r, logic [31:0] d0, logic [31:0] d1);
    @(negedge clk);
    sel[c0] = 1; we[c0] = 1; rg[c0*3 +: 3] = 3'(r); wd[c0*DW +: DW] = d0;
    sel[c1] = 1; we[c1] = 1; rg[c1*3 +: 3] = 3'(r); wd[c1*DW +: DW] = d1;
    @(posedge clk); #1;
    sel[c0] = 0; we[c0] = 0; sel[c1] = 0; we[c1] = 0;
  endtask

  task automatic rd(int c, int r, output logic [31:0] d);
    @(negedge clk);
    sel[c] = 1; we[c] = 0; rg[c*3 +: 3] = 3'(r);
    last_stall = 0;
    #2;
    while (!rdy[c]) begin
      last_stall++;
      @(negedge clk); #2;
    end
    d = rdata[c*DW +: DW];
    @(posedge clk); #1;
    sel[c] = 0;
  endtask

  function automatic logic [31:0] mode(int op, bit whole, bit notify);
    return 32'(op) | (whole ? 32'h2_0000 : 32'h0) | (notify ? 32'h8000 : 32'h0);
  endfunction

  task automatic issue(int c, int op, bit whole, bit notify,
                       logic [31:0] a, logic [31:0] s, output logic [31:0] st);
    wr(c, MREG, mode(op, whole, notify));
    wr(c, AREG, a);
    wr(c, SREG, s);
    rd(c, RSREG, st);
  endtask

  task automatic busy_len(output int n, output logic [1:0] op, output logic wh);
    int guard = 0;
    n = 0; op = 'x; wh = 'x;
    @(negedge clk);
    while (!exec_busy && guard < 1000) begin guard++; @(negedge clk); end
    op = exec_op; wh = exec_whole;
    while (exec_busy && guard < 1000) begin n++; guard++; @(negedge clk); end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 ready", 32'(rdy), 32'h7);
    check("R1 busy", 32'(exec_busy), 0);
    for (int c = 0; c < NCPU; c++) begin
      rd(c, OSREG, v); check("R1 opstat", v, 0);
      rd(c, RSREG, v); check("R1 regstat", v, 0);
    end
  endtask

  task automatic t_range();
    logic [31:0] st, v; int n; logic [1:0] op; logic wh;
    issue(0, 2, 0, 1, 32'h1000, 32'd193, st);
    check("R4 regstat accept", st, 0);
    busy_len(n, op, wh);
    check("R6 four lines", 32'(n), 8);
    check("R11 op flush", 32'(op), 2);
    check("R11 scope range", 32'(wh), 0);
    rd(0, OSREG, v); check("R8 done set", v, 4);
    wr(0, OSREG, 32'h4);
    rd(0, OSREG, v); check("R8 done cleared", v, 0);
  endtask

  task automatic t_unaligned();
    logic [31:0] st, v; int n; logic [1:0] op; logic wh;
    issue(1, 1, 0, 0, 32'h20, 32'd64, st);
    busy_len(n, op, wh);
    check("R6 unaligned two lines", 32'(n), 4);
    rd(1, OSREG, v); check("R8 no notify no flag", v, 0);
    issue(1, 0, 0, 0, 32'h0, 32'd0, st);
    busy_len(n, op, wh);
    check("R6 zero size floor", 32'(n), 1);
  endtask

  task automatic t_whole();
    logic [31:0] st; int n; logic [1:0] op; logic wh;
    issue(2, 0, 1, 1, 32'h40, 32'h10_0000, st);
    busy_len(n, op, wh);
    check("R7 whole duration", 32'(n), ALLL * CPL);
    check("R11 scope whole", 32'(wh), 1);
    check("R11 op inv", 32'(op), 0);
    wr(2, OSREG, 32'h4);
  endtask

  task automatic t_contend();
    logic [31:0] v; int n; logic [1:0] op; logic wh;
    wr2(1, 2, MREG, mode(1, 0, 0), mode(2, 1, 0));
    rd(2, RSREG, v); check("R2 loser fails", v, 1);
    wr(1, AREG, 32'h0);
    wr(1, SREG, 32'd64);
    wr(2, SREG, 32'd640);
    wr(2, AREG, 32'h3f);
    wr(2, MREG, mode(2, 1, 0));
    rd(1, RSREG, v); check("R4 owner accepted", v, 0);
    busy_len(n, op, wh);
    check("R3 outsider size ignored", 32'(n), 2);
    check("R2 winner mode kept", 32'(op), 1);
    rd(2, RSREG, v); check("R2 late writer fails", v, 1);
    rd(2, RSREG, v); check("R2 fail cleared by read", v, 0);
  endtask

  task automatic t_full_order_sync();
    logic [31:0] st, v;
    n_log = 0;
    issue(0, 2, 0, 1, 32'h0, 32'd6400, st);
    wr(1, MREG, mode(0, 1, 1)); rd(1, RSREG, st);
    issue(2, 1, 0, 1, 32'h0, 32'd64, st);
    issue(0, 1, 0, 1, 32'h0, 32'd0, st);
    issue(1, 2, 0, 1, 32'h0, 32'd64, st);
    check("R4 fourth queued", st, 0);
    issue(2, 0, 0, 1, 32'h0, 32'd64, st);
    check("R5 queue full", st, 3);
    rd(1, OSREG, v); check("R9 cpu1 queued", v, 1);
    rd(0, OSREG, v); check("R9 cpu0 running and queued", v, 3);
    wr(2, PREG, 32'd8);
    rd(2, PREG, v);
    check("R10 sync stalled", 32'(last_stall > 0), 1);
    check("R10 drained", 32'(exec_busy), 0);
    rd(1, OSREG, v); check("R8 cpu1 done after drain", v, 4);
    check("R9 count", 32'(n_log), 5);
    check("R9 order 0", 32'(oplog[0]), 2);
    check("R9 order 1", 32'(oplog[1]), 0);
    check("R9 order 2", 32'(oplog[2]), 1);
    check("R9 order 3", 32'(oplog[3]), 1);
    check("R9 order 4", 32'(oplog[4]), 2);
  endtask

  task automatic t_pfflush();
    logic [31:0] st, v;
    wr(0, MREG, mode(0, 1, 0)); rd(0, RSREG, st);
    wr(0, PREG, 32'd9);
    rd(0, PREG, v);
    check("R10 code 9 no stall", 32'(last_stall), 0);
    check("R10 engine still busy", 32'(exec_busy), 1);
    wr(0, PREG, 32'd8);
    rd(0, PREG, v);
    check("R10 sync after 9 drains", 32'(exec_busy), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_range();
    t_unaligned();
    t_whole();
    t_contend();
    t_full_order_sync();
    t_pfflush();
    finish_run();
  end
endmodule